// File: doc/BRIEF.md
# Epoch-Based Wavefront Crossbar Allocator

This block decides, once per epoch, which input ports of a crossbar may send to which output ports. Every input presents a request row with one bit for each output it holds queued traffic for. It does not present only the destination of the packet at the front of its queue, so a packet queued behind a blocked one can still be matched. The allocator builds a matching in which no input drives two outputs and no output receives from two inputs. It finds the matching by sweeping the wrapped diagonals of the request matrix. Once a cell is granted, its row and column drop out of all later diagonals.

Time is split into fixed epochs of `EPOCH_CYCLES` cycles. A matching passes through a fixed pipeline of epochs. Requests are captured in epoch k and matched during epoch k+1. In epoch k+2 the matching is shown on the notify outputs so that ports can prepare. In epoch k+3 it is shown on the transfer outputs, and the data moves. The first diagonal of the sweep advances by one every epoch, so no port pair keeps the top priority.

Top module: `xbw_alloc`

## Requirements
- R1: `epoch_first_o` is high in the first cycle after reset release and then in exactly one cycle of every `EPOCH_CYCLES` (default 16). Epochs are numbered from 0, starting at reset release.
- R2: `req_i` is sampled only in a cycle where `epoch_first_o` is high. Values presented in the other cycles of the epoch have no effect on any grant.
- R3: In every grant matrix, each row (input port i is row i, bits `[i][j]`) has at most one bit set.
- R4: In every grant matrix, each column (output port j is column j) has at most one bit set.
- R5: A grant `[i][j]` is set only if request `[i][j]` was set in the sampled request matrix.
- R6: The matching is maximal. No sampled request `[i][j]` is left ungranted while both row i and column j have no grant.
- R7: Cell `[i][j]` lies on diagonal `(j - i) mod PORTS`. Requests sampled in epoch k are swept one diagonal at a time, starting at diagonal `k mod PORTS` and going upward with wrap. With every request set, epoch k yields grant `[i][(i + k) mod PORTS]` for every i.
- R8: An input whose first requested output is taken on an earlier diagonal is still granted another output it requested, if that output is free.
- R9: Requests sampled in epoch k appear on `ntf_grant_o` for all of epoch k+2. The value is constant through that epoch.
- R10: `xfr_grant_o` during epoch k+3 equals `ntf_grant_o` during epoch k+2.
- R11: While reset is held, and in epochs 0 and 1 after it, both grant matrices and both valid vectors are zero.
- R12: `ntf_vld_o[i]` is high exactly when row i of `ntf_grant_o` has a bit set. `xfr_vld_o[i]` follows the same rule for `xfr_grant_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | PORTS x PORTS | Request matrix; bit [i][j] means input i has traffic for output j |
| epoch_first_o | output | 1 | High in the first cycle of each epoch |
| ntf_vld_o | output | PORTS | Per input: a notified transfer exists |
| ntf_grant_o | output | PORTS x PORTS | Matching announced for the next epoch |
| xfr_vld_o | output | PORTS | Per input: a transfer is under way |
| xfr_grant_o | output | PORTS x PORTS | Matching in force for this epoch |

## Verification
The hardest situation to reach from the ports is rotation wrap-around. The starting diagonal only returns to zero after `PORTS` epochs, so one full-load epoch early in the run cannot cover it. The stimulus therefore applies an all-ones request in epochs 1, 2 and 17, where the last one lands after the diagonal index has wrapped. The expected permutation is computed from the epoch number. To cover the rule that mid-epoch changes are ignored, the stimulus holds a single request in the sampling cycle and floods every request bit for the other fifteen cycles. A hand-placed two-row pattern shows an input being moved to its second choice.

// File: rtl/xbw_pkg.sv
package xbw_pkg;

    localparam int unsigned PORTS_DEF        = 15;
    localparam int unsigned EPOCH_CYCLES_DEF = 16;

    // pipeline stage positions: matched, announced, moving
    localparam int unsigned PIPE_DEPTH = 3;
    localparam int unsigned NOTIFY_IDX = 1;
    localparam int unsigned XFER_IDX   = 2;

    typedef enum logic [1:0] {
        PH_SAMPLE  = 2'd0,
        PH_HOLD    = 2'd1,
        PH_ADVANCE = 2'd2
    } phase_e;

    // (a + b) mod n for 0 <= a, b < n
    function automatic int wrap_sum(input int a, input int b, input int n);
        int s;
        s = a + b;
        return (s >= n) ? s - n : s;
    endfunction

endpackage

// File: rtl/xbw_epoch_timer.sv
module xbw_epoch_timer
    import xbw_pkg::*;
#(
    parameter int unsigned EPOCH_CYCLES = EPOCH_CYCLES_DEF,
    parameter int unsigned PORTS        = PORTS_DEF,
    localparam int unsigned CW = $clog2(EPOCH_CYCLES),
    localparam int unsigned PW = $clog2(PORTS)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    output phase_e        phase_o,
    output logic [PW-1:0] prio_o
);

    localparam logic [CW-1:0] LAST_CYC  = CW'(EPOCH_CYCLES - 1);
    localparam logic [PW-1:0] LAST_PRIO = PW'(PORTS - 1);

    logic [CW-1:0] cyc_q;
    logic [PW-1:0] prio_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cyc_q  <= '0;
            prio_q <= '0;
        end else if (cyc_q == LAST_CYC) begin
            cyc_q  <= '0;
            prio_q <= (prio_q == LAST_PRIO) ? '0 : prio_q + 1'b1;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    always_comb begin
        if (cyc_q == '0)
            phase_o = PH_SAMPLE;
        else if (cyc_q == LAST_CYC)
            phase_o = PH_ADVANCE;
        else
            phase_o = PH_HOLD;
    end

    assign prio_o = prio_q;

    p_epoch_wrap_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o == PH_ADVANCE) |=> (phase_o == PH_SAMPLE));

    p_epoch_single_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o == PH_SAMPLE) |=> (phase_o != PH_SAMPLE));

    p_prio_step_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o == PH_ADVANCE) |=>
            (int'(prio_o) == wrap_sum(int'($past(prio_o)), 1, int'(PORTS))));

    p_prio_still_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o != PH_ADVANCE) |=> $stable(prio_o));

endmodule

// File: rtl/xbw_wavefront.sv
module xbw_wavefront
    import xbw_pkg::*;
#(
    parameter int unsigned PORTS = PORTS_DEF,
    localparam int unsigned PW = $clog2(PORTS)
) (
    input  logic [PORTS-1:0][PORTS-1:0] req_i,
    input  logic [PW-1:0]               prio_i,
    output logic [PORTS-1:0][PORTS-1:0] grant_o
);

    // one stage per diagonal; each stage sees the rows/columns still free
    for (genvar s = 0; s < PORTS; s++) begin : g_diag
        logic [PORTS-1:0]            row_in, col_in, row_out, col_out;
        logic [PORTS-1:0][PORTS-1:0] acc_in, acc_out;

        if (s == 0) begin : g_head
            assign row_in = '1;
            assign col_in = '1;
            assign acc_in = '0;
        end else begin : g_link
            assign row_in = g_diag[s-1].row_out;
            assign col_in = g_diag[s-1].col_out;
            assign acc_in = g_diag[s-1].acc_out;
        end

        always_comb begin
            int dg;
            int cj;
            dg      = wrap_sum(int'(prio_i), s, int'(PORTS));
            row_out = row_in;
            col_out = col_in;
            acc_out = acc_in;
            for (int i = 0; i < PORTS; i++) begin
                cj = wrap_sum(i, dg, int'(PORTS));
                if (req_i[i][cj] && row_in[i] && col_in[cj]) begin
                    acc_out[i][cj] = 1'b1;
                    row_out[i]     = 1'b0;
                    col_out[cj]    = 1'b0;
                end
            end
        end
    end

    assign grant_o = g_diag[PORTS-1].acc_out;

endmodule

// File: rtl/xbw_grant_pipe.sv
module xbw_grant_pipe
    import xbw_pkg::*;
#(
    parameter int unsigned PORTS = PORTS_DEF,
    parameter int unsigned DEPTH = PIPE_DEPTH
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        adv_i,
    input  logic [PORTS-1:0][PORTS-1:0] alloc_i,
    output logic [PORTS-1:0][PORTS-1:0] ntf_o,
    output logic [PORTS-1:0][PORTS-1:0] xfr_o
);

    for (genvar k = 0; k < DEPTH; k++) begin : g_stg
        logic [PORTS-1:0][PORTS-1:0] d, q;

        if (k == 0) begin : g_src
            assign d = alloc_i;
        end else begin : g_chain
            assign d = g_stg[k-1].q;
        end

        always_ff @(posedge clk_i) begin
            if (rst_i)
                q <= '0;
            else if (adv_i)
                q <= d;
        end
    end

    assign ntf_o = g_stg[NOTIFY_IDX].q;
    assign xfr_o = g_stg[XFER_IDX].q;

    p_hold_epoch_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !adv_i |=> ($stable(ntf_o) && $stable(xfr_o)));

    p_notify_to_xfer_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        adv_i |=> (xfr_o == $past(ntf_o)));

endmodule

// File: rtl/xbw_alloc.sv
module xbw_alloc
    import xbw_pkg::*;
#(
    parameter int unsigned PORTS        = PORTS_DEF,
    parameter int unsigned EPOCH_CYCLES = EPOCH_CYCLES_DEF
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic [PORTS-1:0][PORTS-1:0] req_i,
    output logic                        epoch_first_o,
    output logic [PORTS-1:0]            ntf_vld_o,
    output logic [PORTS-1:0][PORTS-1:0] ntf_grant_o,
    output logic [PORTS-1:0]            xfr_vld_o,
    output logic [PORTS-1:0][PORTS-1:0] xfr_grant_o
);

    localparam int unsigned PW = $clog2(PORTS);

    phase_e                      phase;
    logic [PW-1:0]               prio;
    logic [PORTS-1:0][PORTS-1:0] req_q;
    logic [PORTS-1:0][PORTS-1:0] wf_grant;

    xbw_epoch_timer #(
        .EPOCH_CYCLES(EPOCH_CYCLES),
        .PORTS       (PORTS)
    ) timer_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .phase_o(phase),
        .prio_o (prio)
    );

    // request capture: first cycle of the epoch only
    always_ff @(posedge clk_i) begin
        if (rst_i)
            req_q <= '0;
        else if (phase == PH_SAMPLE)
            req_q <= req_i;
    end

    xbw_wavefront #(.PORTS(PORTS)) match_i (
        .req_i  (req_q),
        .prio_i (prio),
        .grant_o(wf_grant)
    );

    xbw_grant_pipe #(.PORTS(PORTS), .DEPTH(PIPE_DEPTH)) pipe_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .adv_i  (phase == PH_ADVANCE),
        .alloc_i(wf_grant),
        .ntf_o  (ntf_grant_o),
        .xfr_o  (xfr_grant_o)
    );

    assign epoch_first_o = (phase == PH_SAMPLE);

    for (genvar i = 0; i < PORTS; i++) begin : g_vld
        assign ntf_vld_o[i] = |ntf_grant_o[i];
        assign xfr_vld_o[i] = |xfr_grant_o[i];
    end

    // column views used by the checks below
    logic [PORTS-1:0][PORTS-1:0] wf_col, ntf_col;
    always_comb begin
        for (int i = 0; i < PORTS; i++)
            for (int j = 0; j < PORTS; j++) begin
                wf_col[j][i]  = wf_grant[i][j];
                ntf_col[j][i] = ntf_grant_o[i][j];
            end
    end

    p_req_frozen_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase != PH_SAMPLE) |=> $stable(req_q));

    for (genvar i = 0; i < PORTS; i++) begin : g_rowchk
        p_row_single_r3: assert property (@(posedge clk_i) disable iff (rst_i)
            $onehot0(wf_grant[i]) && $onehot0(ntf_grant_o[i]));

        p_col_single_r4: assert property (@(posedge clk_i) disable iff (rst_i)
            $onehot0(wf_col[i]) && $onehot0(ntf_col[i]));

        p_grant_requested_r5: assert property (@(posedge clk_i) disable iff (rst_i)
            (wf_grant[i] & ~req_q[i]) == '0);

        for (genvar j = 0; j < PORTS; j++) begin : g_cell
            p_maximal_r6: assert property (@(posedge clk_i) disable iff (rst_i)
                req_q[i][j] |-> ((|wf_grant[i]) || (|wf_col[j])));
        end
    end

endmodule

// File: tb/xbw_alloc_tb.sv
`timescale 1ns/1ps
module xbw_alloc_tb_top;

    localparam int N = 15;
    localparam int L = 16;
    localparam int E = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0][N-1:0] req;
    logic                first;
    logic [N-1:0]        ntf_v, xfr_v;
    logic [N-1:0][N-1:0] ntf_g, xfr_g;

    always #2 clk = ~clk;

    xbw_alloc #(.PORTS(N), .EPOCH_CYCLES(L)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .req_i        (req),
        .epoch_first_o(first),
        .ntf_vld_o    (ntf_v),
        .ntf_grant_o  (ntf_g),
        .xfr_vld_o    (xfr_v),
        .xfr_grant_o  (xfr_g)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural model state
    int                  mcyc, mprio;
    logic [N-1:0][N-1:0] mreq, malloc, mntf, mxfr;
    logic [N-1:0][N-1:0] hist [E];

    task automatic check(input bit ok, input string tag,
                         input logic [N*N-1:0] act, input logic [N*N-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // greedy sweep of diagonals (j-i) mod N, starting at p
    function automatic logic [N-1:0][N-1:0] ref_match(
            input logic [N-1:0][N-1:0] r, input int p);
        logic [N-1:0][N-1:0] g;
        logic [N-1:0] rused, cused;
        g = '0; rused = '0; cused = '0;
        for (int s = 0; s < N; s++) begin
            int d;
            d = (p + s) % N;
            for (int i = 0; i < N; i++) begin
                int j;
                j = (i + d) % N;
                if (r[i][j] && !rused[i] && !cused[j]) begin
                    g[i][j] = 1'b1;
                    rused[i] = 1'b1;
                    cused[j] = 1'b1;
                end
            end
        end
        return g;
    endfunction

    function automatic logic [N-1:0][N-1:0] perm(input int k);
        logic [N-1:0][N-1:0] g;
        g = '0;
        for (int i = 0; i < N; i++) g[i][(i + k) % N] = 1'b1;
        return g;
    endfunction

    task automatic model_edge();
        if (mcyc == 0) mreq = req;
        if (mcyc == L - 1) begin
            mxfr   = mntf;
            mntf   = malloc;
            malloc = ref_match(mreq, mprio);
            mprio  = (mprio + 1) % N;
        end
        mcyc = (mcyc + 1) % L;
    endtask

    task automatic epoch_checks(input int e);
        logic [N-1:0][N-1:0] r, ex;
        bit ok;
        if (e < 2) begin
            check(ntf_g == '0 && xfr_g == '0 && ntf_v == '0 && xfr_v == '0,
                  "R11 early epochs idle", ntf_g | xfr_g, '0);
            return;
        end
        r = hist[e-2];
        // R3 rows
        ok = 1'b1;
        for (int i = 0; i < N; i++) if ($countones(ntf_g[i]) > 1) ok = 1'b0;
        check(ok, "R3 row at most one grant", ntf_g, '0);
        // R4 columns
        ok = 1'b1;
        for (int j = 0; j < N; j++) begin
            int c;
            c = 0;
            for (int i = 0; i < N; i++) c += int'(ntf_g[i][j]);
            if (c > 1) ok = 1'b0;
        end
        check(ok, "R4 column at most one grant", ntf_g, '0);
        check((ntf_g & ~r) == '0, "R5 grant only where requested", ntf_g, r);
        // R6 maximal
        ok = 1'b1;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                bit colfree;
                colfree = 1'b1;
                for (int k = 0; k < N; k++) if (ntf_g[k][j]) colfree = 1'b0;
                if (r[i][j] && ntf_g[i] == '0 && colfree) ok = 1'b0;
            end
        check(ok, "R6 matching maximal", ntf_g, r);
        // R12 valid bits
        ok = 1'b1;
        for (int i = 0; i < N; i++)
            if (ntf_v[i] != (|ntf_g[i]) || xfr_v[i] != (|xfr_g[i])) ok = 1'b0;
        check(ok, "R12 valid follows rows", {ntf_v, xfr_v}, '0);

        case (e)
            2: begin
                ex = '0; ex[0][2] = 1'b1; ex[1][1] = 1'b1;
                check(ntf_g == ex, "R8 second choice granted", ntf_g, ex);
            end
            3: check(ntf_g == perm(1), "R7 full load epoch 1", ntf_g, perm(1));
            4: check(ntf_g == perm(2), "R7 full load epoch 2", ntf_g, perm(2));
            5: begin
                ex = '0; ex[5][7] = 1'b1;
                check(ntf_g == ex, "R2 mid-epoch requests ignored", ntf_g, ex);
                check(xfr_g == perm(2), "R9 transfer three epochs on", xfr_g, perm(2));
            end
            19: check(ntf_g == perm(2), "R7 rotation wrapped epoch 17", ntf_g, perm(2));
            default: ;
        endcase
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R1 watchdog expired act=%0d exp=%0d", 200000, E * L);
        finish_run();
    end

    initial begin
        for (int e = 0; e < E; e++) begin
            for (int i = 0; i < N; i++)
                hist[e][i] = N'($urandom) & N'($urandom) & N'($urandom);
        end
        hist[0] = '0; hist[0][0][1] = 1'b1; hist[0][0][2] = 1'b1; hist[0][1][1] = 1'b1;
        hist[1] = '1;
        hist[2] = '1;
        hist[3] = '0; hist[3][5][7] = 1'b1;
        hist[10] = '0;
        hist[17] = '1;

        mcyc = 0; mprio = 0;
        mreq = '0; malloc = '0; mntf = '0; mxfr = '0;
        req = '1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ntf_g == '0 && xfr_g == '0 && ntf_v == '0 && xfr_v == '0,
              "R11 reset state", ntf_g | xfr_g, '0);
        rst = 1'b0;

        for (int e = 0; e < E; e++) begin
            for (int c = 0; c < L; c++) begin
                check(first == (mcyc == 0), "R1 epoch marker", first, (mcyc == 0));
                check(ntf_g == mntf, "R9 notify matrix", ntf_g, mntf);
                check(xfr_g == mxfr, "R10 transfer matrix", xfr_g, mxfr);
                if (c == 0) epoch_checks(e);
                if (c == 0)
                    req = hist[e];
                else if (e == 3)
                    req = '1;
                else
                    for (int i = 0; i < N; i++) req[i] = N'($urandom);
                @(posedge clk);
                model_edge();
                @(negedge clk);
            end
        end
        finish_run();
    end

endmodule